// File: doc/BRIEF.md
# Interpolated Lookup Function Evaluator

This block evaluates a smooth, monotonically non-decreasing function of an unsigned fraction, with square root as the main case. Each input word is split in two. The upper bits address a small constant table, and the lower bits give a fraction that places the input between two neighbouring table points. The block reads both neighbouring entries in the same cycle. It then forms the result as the lower entry plus the entry difference scaled by the fraction.

The interface is a valid-qualified sample stream in each direction. A new sample may arrive on every clock. Its result leaves on the output a fixed number of cycles later, with no stalls. The table is filled at elaboration by a function, and a parameter chooses the shape: square root or square. One special rule applies when both neighbouring entries are zero. In that case the difference is replaced by a programmable constant, so the flat start of a function such as the square still gives a usable slope.

Top module: `ilut_eval`

## Requirements
- R1: The upper 10 input bits select table entry a, and the lower 6 bits are the fraction f (bit 5 weighs 1/2). When f = 0 the output equals entry a exactly, and an input of 0 gives an output of 0.
- R2: For any input, the output is lo + floor(d·f / 64). Here lo is entry a, hi is entry a+1 and d = hi − lo. Only the upper 17 bits of the 23-bit product are kept, and all values are unsigned.
- R3: The table has 1025 entries. Inputs in the top segment (a = 1023) interpolate toward entry 1024. That entry is the value at 1.0, clipped to the largest 17-bit code (131071).
- R4: When entries a and a+1 are both zero, d is replaced by the parameter FORCE_DIFF (default 32). With the square table, inputs with a < 2 therefore give floor(32·f / 64).
- R5: Each accepted sample gives its result exactly 10 clock cycles later. Inputs presented back-to-back give outputs back-to-back, in the same order.
- R6: out_valid is the input valid delayed by 10 cycles. A synchronous active-high reset drops every sample in flight, so out_valid is low during reset and for 10 cycles after it.
- R7: With the square-root table and inputs of at least 0x1000, the output stays within 3 LSBs of sqrt(x/65536)·131072.
- R8: FUNC_SEL = 0 fills entry i with floor(sqrt(i/1024)·2^17). FUNC_SEL = 1 fills it with floor(i²/8), the square scaled to 17 fractional bits. Both are clipped to 131071.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the valid pipeline |
| in_valid | input | 1 | Input sample qualifier |
| in_x | input | 16 | Unsigned input, all bits fractional |
| out_valid | output | 1 | Output sample qualifier |
| out_y | output | 17 | Unsigned result, all bits fractional |

## Verification
The two functions that meet in one cycle are the acceptance of a new sample and the release of a result from ten cycles earlier. The bench keeps the input busy on every clock while results stream out. It judges each result against both its value and its cycle stamp. In the square variant, a forced-difference sample (a = 1) is placed directly before an ordinary one (a = 2). This checks that the zero-pair substitution follows only its own sample through the pipeline. A reset is also applied while samples are in flight, and the bench judges that none of them appears afterwards.

// File: rtl/ilut_pkg.sv
package ilut_pkg;

  localparam int FN_SQRT   = 0;
  localparam int FN_SQUARE = 1;

  // Integer square root by bit-by-bit trial (elaboration time only).
  function automatic longint unsigned isqrt64(input longint unsigned n);
    longint unsigned root;
    longint unsigned trial;
    root = 0;
    for (int k = 31; k >= 0; k--) begin
      trial = root | (64'd1 << k);
      if (trial * trial <= n) root = trial;
    end
    return root;
  endfunction

  // Table point idx of a function sampled on 2^a_w segments of [0,1].
  function automatic longint unsigned table_entry(input int func, input int idx,
                                                  input int a_w, input int d_w);
    longint unsigned v;
    longint unsigned top;
    longint unsigned i;
    i   = longint'(idx);
    top = (64'd1 << d_w) - 1;
    if (func == FN_SQUARE) begin
      if (2 * a_w >= d_w) v = (i * i) >> (2 * a_w - d_w);
      else                v = (i * i) << (d_w - 2 * a_w);
    end else begin
      v = isqrt64(i << (2 * d_w - a_w));
    end
    if (v > top) v = top;
    return v;
  endfunction

endpackage

// File: rtl/ilut_delay.sv
module ilut_delay #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  generate
    if (STAGES == 0) begin : g_wire
      assign dout = din;
    end else begin : g_regs
      logic [WIDTH-1:0] stage_q [STAGES];
      always_ff @(posedge clk) begin
        stage_q[0] <= din;
        for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
      end
      assign dout = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/ilut_rom.sv
module ilut_rom #(
  parameter int ADDR_W   = 10,
  parameter int DATA_W   = 17,
  parameter int FUNC_SEL = 0
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] seg_addr,
  output logic [DATA_W-1:0] lo_q,
  output logic [DATA_W-1:0] hi_q
);

  localparam int DEPTH = (1 << ADDR_W) + 1;
  localparam int IDX_W = ADDR_W + 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rd_lo, rd_hi;
  logic [IDX_W-1:0]  idx_lo, idx_hi;

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = DATA_W'(ilut_pkg::table_entry(FUNC_SEL, i, ADDR_W, DATA_W));
  end

  assign idx_lo = {1'b0, seg_addr};
  assign idx_hi = idx_lo + IDX_W'(1);

  // Two synchronous read ports, then an output register.
  always_ff @(posedge clk) begin
    rd_lo <= mem[idx_lo];
    rd_hi <= mem[idx_hi];
  end

  always_ff @(posedge clk) begin
    lo_q <= rd_lo;
    hi_q <= rd_hi;
  end

endmodule

// File: rtl/ilut_interp.sv
module ilut_interp #(
  parameter int DATA_W     = 17,
  parameter int FRAC_W     = 6,
  parameter int FORCE_DIFF = 32
) (
  input  logic              clk,
  input  logic [DATA_W-1:0] lo,
  input  logic [DATA_W-1:0] hi,
  input  logic [FRAC_W-1:0] frac,
  output logic [DATA_W-1:0] y
);

  localparam int PROD_W = DATA_W + FRAC_W;
  localparam logic [DATA_W-1:0] FORCE_V = DATA_W'(FORCE_DIFF);

  logic [DATA_W-1:0] diff_q, lo4_q, lo5_q, lo6_q, scaled_q, sum_q;
  logic [FRAC_W-1:0] frac4_q;
  logic [PROD_W-1:0] prod_q;
  logic              zero_pair;

  assign zero_pair = (lo == '0) && (hi == '0);

  // Stage: difference with zero-pair substitution.
  always_ff @(posedge clk) begin
    diff_q  <= zero_pair ? FORCE_V : (hi - lo);
    lo4_q   <= lo;
    frac4_q <= frac;
  end

  // Stage: full-width product.
  always_ff @(posedge clk) begin
    prod_q <= PROD_W'(diff_q) * PROD_W'(frac4_q);
    lo5_q  <= lo4_q;
  end

  // Stage: drop the fraction bits of the product.
  always_ff @(posedge clk) begin
    scaled_q <= prod_q[PROD_W-1:FRAC_W];
    lo6_q    <= lo5_q;
  end

  // Stage: accumulate onto the lower entry.
  always_ff @(posedge clk) begin
    sum_q <= lo6_q + scaled_q;
  end

  assign y = sum_q;

endmodule

// File: rtl/ilut_eval.sv
module ilut_eval #(
  parameter int IN_W       = 16,
  parameter int ADDR_W     = 10,
  parameter int OUT_W      = 17,
  parameter int LATENCY    = 10,
  parameter int FUNC_SEL   = 0,
  parameter int FORCE_DIFF = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [IN_W-1:0]  in_x,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_y
);

  localparam int FRAC_W   = IN_W - ADDR_W;
  localparam int CORE_LAT = 7;
  localparam int PAD      = LATENCY - CORE_LAT;

  logic [IN_W-1:0]    x_q;
  logic [LATENCY-1:0] vld_q;
  logic [FRAC_W-1:0]  frac_al;
  logic [OUT_W-1:0]   lo_w, hi_w, sum_w;

  always_ff @(posedge clk) x_q <= in_x;

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else     vld_q <= {vld_q[LATENCY-2:0], in_valid};
  end

  ilut_rom #(.ADDR_W(ADDR_W), .DATA_W(OUT_W), .FUNC_SEL(FUNC_SEL)) rom_i (
    .clk(clk), .seg_addr(x_q[IN_W-1:FRAC_W]), .lo_q(lo_w), .hi_q(hi_w)
  );

  ilut_delay #(.WIDTH(FRAC_W), .STAGES(2)) frac_dly_i (
    .clk(clk), .din(x_q[FRAC_W-1:0]), .dout(frac_al)
  );

  ilut_interp #(.DATA_W(OUT_W), .FRAC_W(FRAC_W), .FORCE_DIFF(FORCE_DIFF)) interp_i (
    .clk(clk), .lo(lo_w), .hi(hi_w), .frac(frac_al), .y(sum_w)
  );

  ilut_delay #(.WIDTH(OUT_W), .STAGES(PAD)) out_dly_i (
    .clk(clk), .din(sum_w), .dout(out_y)
  );

  assign out_valid = vld_q[LATENCY-1];

endmodule

// File: rtl/ilut_eval_chk.sv
module ilut_eval_chk #(
  parameter int IN_W       = 16,
  parameter int ADDR_W     = 10,
  parameter int OUT_W      = 17,
  parameter int LATENCY    = 10,
  parameter int FUNC_SEL   = 0,
  parameter int FORCE_DIFF = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [IN_W-1:0]  in_x,
  input logic             out_valid,
  input logic [OUT_W-1:0] out_y
);

  localparam int FRAC_W = IN_W - ADDR_W;

  logic [LATENCY-1:0] vh;
  logic [IN_W-1:0]    xh [LATENCY];
  logic [IN_W-1:0]    x_old, prev_x;
  logic [OUT_W-1:0]   prev_y, forced_y;
  logic               prev_ok;

  always_ff @(posedge clk) begin
    if (rst) vh <= '0;
    else     vh <= {vh[LATENCY-2:0], in_valid};
    xh[0] <= in_x;
    for (int s = 1; s < LATENCY; s++) xh[s] <= xh[s-1];
  end

  assign x_old    = xh[LATENCY-1];
  assign forced_y = OUT_W'((FORCE_DIFF * int'(x_old[FRAC_W-1:0])) >> FRAC_W);

  always_ff @(posedge clk) begin
    if (rst) prev_ok <= 1'b0;
    else if (out_valid) begin
      prev_ok <= 1'b1;
      prev_x  <= x_old;
      prev_y  <= out_y;
    end
  end

  // R6
  rst_clear_chk: assert property (@(posedge clk) rst |=> !out_valid);

  // R5
  valid_delay_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid == vh[LATENCY-1]);

  // R1
  zero_in_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && x_old == '0) |-> (out_y == '0));

  // R4
  forced_diff_chk: assert property (@(posedge clk) disable iff (rst)
    (FUNC_SEL == 1 && out_valid && x_old[IN_W-1:FRAC_W] < 2) |-> (out_y == forced_y));

  // R2
  monotone_chk: assert property (@(posedge clk) disable iff (rst)
    (FUNC_SEL == 0 && out_valid && prev_ok && x_old >= prev_x) |-> (out_y >= prev_y));

endmodule

bind ilut_eval ilut_eval_chk #(
  .IN_W(IN_W), .ADDR_W(ADDR_W), .OUT_W(OUT_W), .LATENCY(LATENCY),
  .FUNC_SEL(FUNC_SEL), .FORCE_DIFF(FORCE_DIFF)
) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x),
  .out_valid(out_valid), .out_y(out_y)
);

// File: tb/ilut_eval_tb_top.sv
`timescale 1ns/1ps
module ilut_eval_tb_top;

  localparam int IN_W = 16, OUT_W = 17, FRAC_W = 6, LAT = 10, FORCE = 32;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst = 1'b1, in_valid = 1'b0;
  logic [IN_W-1:0]  in_x = '0;
  logic             ov_s, ov_q;
  logic [OUT_W-1:0] y_s, y_q;

  ilut_eval #(.FUNC_SEL(0)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .out_valid(ov_s), .out_y(y_s));
  ilut_eval #(.FUNC_SEL(1)) dut_sq_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .out_valid(ov_q), .out_y(y_q));

  typedef struct {
    int unsigned x;
    longint      y;
    int          stamp;
    string       tag;
  } item_t;

  item_t q_s[$];
  item_t q_q[$];
  int checks = 0, errors = 0, cyc = 0;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic longint tbl(input int func, input int i);
    longint v, n;
    if (func == 1) v = (longint'(i) * i) >>> 3;
    else begin
      n = longint'(i) << 24;
      v = longint'($sqrt(real'(n)));
      while ((v + 1) * (v + 1) <= n) v++;
      while (v * v > n) v--;
    end
    if (v > 131071) v = 131071;
    return v;
  endfunction

  function automatic longint model(input int func, input int unsigned x);
    longint lo, hi, d;
    int a, f;
    a = int'(x >> FRAC_W); f = int'(x & 63);
    lo = tbl(func, a); hi = tbl(func, a + 1);
    d = (lo == 0 && hi == 0) ? FORCE : hi - lo;
    return lo + ((d * f) >>> FRAC_W);
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic mon(ref item_t q[$], input logic v, input logic [OUT_W-1:0] y,
                     input bit is_sqrt);
    item_t it;
    real r, e;
    if (rst) return;
    if (v) begin
      if (q.size() == 0) check(0, "R6", "output with nothing in flight", 1, 0);
      else begin
        it = q.pop_front();
        check(cyc == it.stamp, "R5", "output cycle", cyc, it.stamp);
        check(longint'(y) == it.y, it.tag, $sformatf("value for x=%h", it.x), y, it.y);
        if (is_sqrt && it.x >= 32'h1000) begin
          r = $sqrt(real'(it.x) / 65536.0) * 131072.0;
          e = real'(y) - r;
          if (e < 0.0) e = -e;
          check(e <= 3.0, "R7", $sformatf("accuracy x=%h", it.x), y, longint'(r));
        end
      end
    end else if (q.size() > 0 && q[0].stamp <= cyc) begin
      check(0, "R5", "missing output at cycle", cyc, q[0].stamp);
      void'(q.pop_front());
    end
  endtask

  always @(negedge clk) mon(q_s, ov_s, y_s, 1'b1);
  always @(negedge clk) mon(q_q, ov_q, y_q, 1'b0);

  task automatic send(input logic v, input logic [IN_W-1:0] x);
    item_t a, b;
    int seg;
    @(negedge clk);
    in_valid = v;
    in_x     = x;
    if (v) begin
      seg = int'(x >> FRAC_W);
      a.x = x; a.y = model(0, x); a.stamp = cyc + LAT;
      a.tag = (x[5:0] == 0) ? "R1" : (seg == 1023) ? "R3" : "R2";
      b.x = x; b.y = model(1, x); b.stamp = cyc + LAT;
      b.tag = (seg < 2) ? "R4" : "R8";
      q_s.push_back(a);
      q_q.push_back(b);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R5 watchdog: actual cycle %0d expected below %0d", cyc, 100000);
    finish_run();
  end

  initial begin
    logic [IN_W-1:0] dir [15];
    dir = '{16'h0000, 16'h0040, 16'h0020, 16'h003F, 16'h0041, 16'h007F, 16'h0080,
            16'h00C5, 16'h1000, 16'h4000, 16'h8000, 16'hFFC0, 16'hFFE1, 16'hFFFF, 16'h0001};
    repeat (3) @(negedge clk);
    // R6: reset state
    check(ov_s == 1'b0, "R6", "sqrt out_valid in reset", ov_s, 0);
    check(ov_q == 1'b0, "R6", "square out_valid in reset", ov_q, 0);
    rst = 1'b0;
    repeat (12) send(1'b0, '0);
    // R1 R2 R3 R4: directed points back to back
    foreach (dir[i]) send(1'b1, dir[i]);
    // R5 R7 R8: dense sweep, then gapped traffic
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(1'b1, lfsr);
    end
    for (int n = 0; n < 200; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(lfsr[3], lfsr);
    end
    repeat (15) send(1'b0, '0);
    // R6: reset with samples in flight
    for (int n = 0; n < 5; n++) send(1'b1, 16'h2000 + 16'(n * 97));
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    q_s.delete(); q_q.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      check(ov_s == 1'b0 && ov_q == 1'b0, "R6", "out_valid after flush", ov_s | ov_q, 0);
    end
    // R4 R8: forced segment next to an ordinary one
    send(1'b1, 16'h0050); send(1'b1, 16'h00A0); send(1'b1, 16'h0055); send(1'b1, 16'h00FF);
    repeat (15) send(1'b0, '0);
    check(q_s.size() == 0 && q_q.size() == 0, "R5", "items left in flight",
          q_s.size() + q_q.size(), 0);
    finish_run();
  end

endmodule